// File: doc/BRIEF.md
# Interrupt Credit Moderator

This block throttles the completion interrupt of one descriptor ring. The completion logic pulses an input once for each descriptor it finishes. The block keeps a running count of finished descriptors that software has not yet consumed. Software hands back the descriptors it has processed by writing a count to the credit-return input. That count is subtracted from the running total.

The block has a gate that shuts automatically. While the gate is open, the first completion raises an interrupt request and closes the gate. While the gate is closed, further completions only add to the count. Each credit-return write then settles the gate:
- If the write leaves descriptors outstanding, the block raises another request so that software comes back for them, and the gate stays closed.
- If the write takes the count to zero, the gate reopens and no request is raised.

This gate is separate from any per-vector mask kept by the message-signalled interrupt logic downstream. Each request is a one-cycle pulse that carries the vector number of the ring. The vector number is fixed by the ring's index.

Top module: `icm_moderator`

## Requirements
- R1: Each cycle in which `cmpl_i` is high raises `credits_o` by one on the following clock edge, unless a credit return is applied in the same cycle (R7).
- R2: While the gate is open, a completion that leaves a nonzero count produces exactly one `irq_o` pulse.
- R3: After `irq_o` fires from an open gate, the gate is closed. Further completions with no credit-return write raise no request.
- R4: A credit-return write that brings the count to exactly zero raises no request and reopens the gate, so the next completion fires again.
- R5: A credit-return write that leaves a nonzero count raises one request and keeps the gate closed. A write of zero credits counts as such a write.
- R6: A credit return larger than the count plus the same-cycle completion sets the count to zero and sets `over_ret_o`. Once set, `over_ret_o` stays high until reset. The result of zero is then handled as in R4.
- R7: When a completion and a credit-return write arrive in the same cycle, the new count is the old count plus one minus the returned value.
- R8: `irq_o` is high for one cycle, in the cycle after the triggering input. When it is high, `irq_vec_o` holds the ring vector. That vector is the ring index for rings 0 and 1, and the ring index plus 2 for ring 2 and above. This makes transmit rings (even index) land on even vectors from 4, and receive rings on odd vectors from 5.
- R9: A completion when the count is already all ones leaves the count at all ones.
- R10: After reset, `credits_o` is 0, `irq_o` and `over_ret_o` are 0, and the gate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_i | input | 1 | One descriptor completed this cycle |
| cred_wr_i | input | 1 | Credit-return write strobe |
| cred_val_i | input | CNT_W | Number of credits returned |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | 8 | Vector of the request |
| credits_o | output | CNT_W | Outstanding credit count |
| over_ret_o | output | 1 | Sticky flag: more credits returned than outstanding |

## Verification
A wrong count appears on `credits_o` at the next clock edge. A gate stuck in the wrong state shows up on `irq_o` at the next completion or credit-return write.
- A gate stuck closed never raises the request for the first completion after a full return.
- A gate stuck open raises requests on every completion.

Because errors surface this quickly, the bench compares every output in every cycle against a reference model. It does so under random mixes of completions, partial returns, full returns and over-returns, including cycles where a completion and a return coincide.

// File: rtl/icm_pkg.sv
package icm_pkg;

    localparam int VEC_W = 8;

    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } irq_req_t;

    // Rings 0/1 map directly; data rings skip vectors 2 and 3.
    function automatic logic [VEC_W-1:0] ring_vector(input int ring);
        int v;
        v = (ring < 2) ? ring : ring + 2;
        return v[VEC_W-1:0];
    endfunction

endpackage

// File: rtl/icm_credit_cnt.sv
module icm_credit_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmpl,
    input  logic             ret_wr,
    input  logic [CNT_W-1:0] ret_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             nxt_zero,
    output logic             err_q
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [SUM_W-1:0] sum_raw;
    logic [CNT_W-1:0] sum_sat;
    logic [CNT_W-1:0] dec;
    logic             over;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        sum_raw  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, cmpl};
        sum_sat  = sum_raw[CNT_W] ? CNT_MAX : sum_raw[CNT_W-1:0];
        dec      = ret_wr ? ret_val : '0;
        over     = dec > sum_sat;
        cnt_d    = over ? '0 : (sum_sat - dec);
        nxt_zero = (cnt_d == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (over) err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/icm_gate_ctrl.sv
module icm_gate_ctrl
    import icm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmpl,
    input  logic  ret_wr,
    input  logic  nxt_zero,
    output gate_e gate_q,
    output logic  fire
);
    gate_e gate_d;

    always_comb begin
        fire   = 1'b0;
        gate_d = gate_q;
        if (gate_q == GATE_OPEN) begin
            if (cmpl && !nxt_zero) begin
                fire   = 1'b1;
                gate_d = GATE_SHUT;
            end
        end else if (ret_wr) begin
            if (nxt_zero) gate_d = GATE_OPEN;
            else          fire   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) gate_q <= GATE_OPEN;
        else     gate_q <= gate_d;
    end
endmodule

// File: rtl/icm_irq_emit.sv
module icm_irq_emit
    import icm_pkg::*;
#(
    parameter int RING_ID = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     fire,
    output irq_req_t req_q
);
    localparam logic [VEC_W-1:0] MY_VEC = ring_vector(RING_ID);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q.valid <= fire;
            req_q.vec   <= fire ? MY_VEC : '0;
        end
    end
endmodule

// File: rtl/icm_moderator.sv
module icm_moderator
    import icm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RING_ID = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmpl_i,
    input  logic             cred_wr_i,
    input  logic [CNT_W-1:0] cred_val_i,
    output logic             irq_o,
    output logic [7:0]       irq_vec_o,
    output logic [CNT_W-1:0] credits_o,
    output logic             over_ret_o
);
    logic     nxt_zero;
    logic     fire;
    gate_e    gate_q;
    irq_req_t req;

    icm_credit_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmpl     (cmpl_i),
        .ret_wr   (cred_wr_i),
        .ret_val  (cred_val_i),
        .cnt_q    (credits_o),
        .nxt_zero (nxt_zero),
        .err_q    (over_ret_o)
    );

    icm_gate_ctrl i_gate (
        .clk      (clk),
        .rst      (rst),
        .cmpl     (cmpl_i),
        .ret_wr   (cred_wr_i),
        .nxt_zero (nxt_zero),
        .gate_q   (gate_q),
        .fire     (fire)
    );

    icm_irq_emit #(.RING_ID(RING_ID)) i_emit (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .req_q (req)
    );

    assign irq_o     = req.valid;
    assign irq_vec_o = req.vec;
endmodule

// File: rtl/icm_checker.sv
module icm_checker #(
    parameter int CNT_W   = 16,
    parameter int RING_ID = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cmpl_i,
    input logic             cred_wr_i,
    input logic [CNT_W-1:0] cred_val_i,
    input logic             irq_o,
    input logic [7:0]       irq_vec_o,
    input logic [CNT_W-1:0] credits_o,
    input logic             over_ret_o,
    input logic             gate_open
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam int EXP_VEC = (RING_ID < 2) ? RING_ID : RING_ID + 2;

    // R1
    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        (cmpl_i && !cred_wr_i && credits_o != TOP) |=> credits_o == $past(credits_o) + 1'b1);
    // R2
    a_r2_first_fires: assert property (@(posedge clk) disable iff (rst)
        (gate_open && cmpl_i && !cred_wr_i) |=> irq_o);
    // R3
    a_r3_masked_after: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !gate_open);
    a_r3_quiet_shut: assert property (@(posedge clk) disable iff (rst)
        (!gate_open && !cred_wr_i) |=> !irq_o);
    // R4
    a_r4_full_return: assert property (@(posedge clk) disable iff (rst)
        (cred_wr_i && !cmpl_i && cred_val_i == credits_o && credits_o != '0)
        |=> (!irq_o && credits_o == '0 && gate_open));
    // R5
    a_r5_partial_return: assert property (@(posedge clk) disable iff (rst)
        (cred_wr_i && !cmpl_i && cred_val_i < credits_o && !gate_open) |=> (irq_o && !gate_open));
    // R6
    a_r6_over_return: assert property (@(posedge clk) disable iff (rst)
        (cred_wr_i && credits_o != TOP &&
         {1'b0, cred_val_i} > ({1'b0, credits_o} + {{CNT_W{1'b0}}, cmpl_i}))
        |=> (credits_o == '0 && over_ret_o));
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        over_ret_o |=> over_ret_o);
    // R7
    a_r7_same_cycle: assert property (@(posedge clk) disable iff (rst)
        (cmpl_i && cred_wr_i && cred_val_i <= credits_o && credits_o != TOP)
        |=> credits_o == $past(credits_o) + 1'b1 - $past(cred_val_i));
    // R8
    a_r8_vector: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> irq_vec_o == 8'(EXP_VEC));
    // R9
    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (cmpl_i && !cred_wr_i && credits_o == TOP) |=> credits_o == TOP);
endmodule

bind icm_moderator icm_checker #(.CNT_W(CNT_W), .RING_ID(RING_ID)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .cmpl_i     (cmpl_i),
    .cred_wr_i  (cred_wr_i),
    .cred_val_i (cred_val_i),
    .irq_o      (irq_o),
    .irq_vec_o  (irq_vec_o),
    .credits_o  (credits_o),
    .over_ret_o (over_ret_o),
    .gate_open  (gate_q == icm_pkg::GATE_OPEN)
);

// File: tb/test_icm_moderator.sv
module test_icm_moderator;
    localparam int CNT_W   = 4;
    localparam int RING_ID = 5;
    localparam int MAXC    = (1 << CNT_W) - 1;
    localparam int VEC     = RING_ID + 2; // R8: ring 5 (receive) -> vector 7

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmpl_i = 1'b0;
    logic             cred_wr_i = 1'b0;
    logic [CNT_W-1:0] cred_val_i = '0;
    logic             irq_o;
    logic [7:0]       irq_vec_o;
    logic [CNT_W-1:0] credits_o;
    logic             over_ret_o;

    int checks = 0;
    int fails  = 0;
    int m_cnt  = 0;
    bit m_open = 1'b1;
    bit m_err  = 1'b0;
    bit m_irq  = 1'b0;

    always #5 clk = ~clk;

    icm_moderator #(.CNT_W(CNT_W), .RING_ID(RING_ID)) i_icm_moderator (
        .clk(clk), .rst(rst), .cmpl_i(cmpl_i), .cred_wr_i(cred_wr_i),
        .cred_val_i(cred_val_i), .irq_o(irq_o), .irq_vec_o(irq_vec_o),
        .credits_o(credits_o), .over_ret_o(over_ret_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int next_count(input int cnt, input bit c, input bit w, input int v);
        int s;
        s = (c && cnt < MAXC) ? cnt + 1 : cnt;
        if (!w) return s;
        return (v > s) ? 0 : s - v;
    endfunction

    task automatic step(input bit c, input bit w, input int v, input string tag);
        int nc;
        int s;
        cmpl_i     = c;
        cred_wr_i  = w;
        cred_val_i = v[CNT_W-1:0];
        s  = (c && m_cnt < MAXC) ? m_cnt + 1 : m_cnt;
        nc = next_count(m_cnt, c, w, v);
        if (w && v > s) m_err = 1'b1;
        if (m_open) begin
            m_irq  = c && nc != 0;
            m_open = !m_irq;
        end else begin
            m_irq  = w && nc != 0;
            m_open = w && nc == 0;
        end
        m_cnt = nc;
        @(negedge clk);
        check({tag, " credits"}, int'(credits_o), m_cnt);
        check({tag, " irq"}, int'(irq_o), int'(m_irq));
        check({tag, " over_ret"}, int'(over_ret_o), int'(m_err));
        if (m_irq) check({tag, " vector R8"}, int'(irq_vec_o), VEC);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset credits", int'(credits_o), 0);
        check("R10 reset irq", int'(irq_o), 0);
        check("R10 reset over_ret", int'(over_ret_o), 0);

        step(1, 0, 0, "R2 first completion");
        step(0, 0, 0, "R8 pulse ends");
        step(1, 0, 0, "R3 masked completion");
        step(1, 0, 0, "R3 masked completion");
        step(1, 0, 0, "R1 count to four");
        step(0, 1, 1, "R5 partial return");
        step(0, 1, 0, "R5 zero-credit write");
        step(0, 1, 3, "R4 full return");
        step(1, 0, 0, "R4 reopened gate fires");
        step(1, 1, 1, "R7 same-cycle return");
        step(0, 1, 5, "R6 over return");
        step(0, 0, 0, "R6 flag sticky");
        step(1, 0, 0, "R6 gate reopened");
        for (int i = 0; i < 20; i++) step(1, 0, 0, "R9 saturate");
        step(0, 1, MAXC, "R4 drain from top");

        for (int i = 0; i < 3000; i++) begin
            bit c, w;
            int v;
            c = 1'($urandom % 2);
            w = ($urandom % 4) == 0;
            v = int'($urandom % (m_cnt + 3));
            if (v > MAXC) v = MAXC;
            step(c, w, v, "R7 random mix");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule